// File: doc/BRIEF.md
# Oscillator Band Search Sequencer

This block picks the oscillator and sub-band that a synthesizer should run on after its target frequency changes. There are three oscillators, each split into sixteen sub-bands, so the search covers 48 settings. A search starts on a one-clock pulse that marks a write of the lowest fractional-divider byte, but only when the search enable is set. The starting setting is either the manually programmed oscillator and sub-band fields or the setting that is in use at that moment.

For each setting it tries, the sequencer waits a settling time chosen by a two-bit field. It then samples a three-bit code taken from the tuning voltage. An all-zeros code moves the search one sub-band down and an all-ones code moves it one sub-band up. Any other code means the loop is locked, and the search stops on the current setting. The search also stops, and reports failure, if it would step past either end of the oscillator range or if it uses up its budget of tries. The analog oscillators, the converter and the loop itself lie outside this block.

Top module: `vco_band_search`

## Requirements
- R1: After reset, `srch_idle` is 1 and `srch_ok` is 0. With `srch_en` = 1, the selected setting is oscillator 0, sub-band 0.
- R2: While `srch_en` is 0, `osc_sel` and `sub_sel` equal `man_osc` and `man_sub` in the same cycle, and `srch_ok` is 0. A `retune` pulse starts nothing, so `srch_idle` stays 1. The setting in use follows the manual fields.
- R3: A `retune` pulse sampled with `srch_en` = 1 starts a search. `srch_idle` is 0 and `srch_ok` is 0 from the next clock.
- R4: If `seed_cur` = 0, the search starts from `man_osc`/`man_sub`. If `seed_cur` = 1, it starts from the oscillator and sub-band in use when the pulse arrives.
- R5: Each code sample is taken exactly 2^(6+W) clocks after the start or after the previous sample. W is `settle_sel`, captured at the start. A search that ends after k samples raises `srch_idle` k·2^(6+W) clocks after the start edge.
- R6: A sampled code from 3'b001 to 3'b110 ends the search. `srch_idle` is then 1 and `srch_ok` is 1, and the setting is left unchanged.
- R7: Code 3'b000 moves one sub-band down. From sub-band 0, the search moves to sub-band 15 of the next lower oscillator.
- R8: Code 3'b111 moves one sub-band up. From sub-band 15, the search moves to sub-band 0 of the next higher oscillator.
- R9: A step down from oscillator 0, sub-band 0, or a step up from oscillator 2, sub-band 15, ends the search. `srch_ok` is 0 and the last setting tried is kept.
- R10: If the 48th sample of one search is unlocked, the search ends with `srch_ok` = 0 and keeps that sample's setting.
- R11: A `retune` pulse during an active search restarts it. The try count and settling timer are cleared, and the start point is reloaded. The restart takes priority over a sample due on the same clock.
- R12: A search whose start oscillator is the shutdown code 2'b11 fails at its first sample, whatever the code. The setting is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retune | input | 1 | One-clock pulse marking a write of the lowest fractional byte |
| srch_en | input | 1 | Search enable; 0 = manual selection |
| seed_cur | input | 1 | Start point: 0 = manual fields, 1 = setting in use |
| man_osc | input | 2 | Programmed oscillator (2'b11 = shutdown) |
| man_sub | input | 4 | Programmed sub-band |
| settle_sel | input | 2 | Settling-time selector W (2^(6+W) clocks) |
| vt_code | input | 3 | Tuning-voltage code |
| osc_sel | output | 2 | Oscillator in use |
| sub_sel | output | 4 | Sub-band in use |
| srch_idle | output | 1 | 1 when no search is active |
| srch_ok | output | 1 | 1 after a successful search |

## Verification
A restart pulse and a scheduled code sample can fall on the same clock edge. The bench provokes this by raising the second pulse exactly three settling periods after the first start. Restart must win: the result must show the reloaded start point, and the elapsed time must be counted from the second pulse. A second coincidence occurs when a step-limit failure and a normal up/down step could both apply to the same sample. A bouncing code pattern keeps two neighbouring sub-bands alternating, so only the try budget can end the search. It must then stop on the 48th sample with the failure flag.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
   typedef enum logic {
      S_IDLE = 1'b0,
      S_WAIT = 1'b1
   } vbs_state_e;

   typedef enum logic [1:0] {
      ACT_LOCK = 2'd0,
      ACT_DOWN = 2'd1,
      ACT_UP   = 2'd2
   } vbs_act_e;
endpackage

// File: rtl/vbs_code_decode.sv
module vbs_code_decode
   import vbs_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic [CODE_W-1:0] code,
   output vbs_act_e          act
);
   localparam logic [CODE_W-1:0] CODE_LO = '0;
   localparam logic [CODE_W-1:0] CODE_HI = '1;

   generate
      if (CODE_W < 2) begin : g_bad_width
         $error("vbs_code_decode: CODE_W must be at least 2");
      end
   endgenerate

   always_comb begin
      if (code == CODE_LO)      act = ACT_DOWN;
      else if (code == CODE_HI) act = ACT_UP;
      else                      act = ACT_LOCK;
   end
endmodule

// File: rtl/vbs_stepper.sv
module vbs_stepper #(
   parameter int OSC_W   = 2,
   parameter int SUB_W   = 4,
   parameter int NUM_OSC = 3
) (
   input  logic [OSC_W-1:0] osc,
   input  logic [SUB_W-1:0] sub,
   input  logic             dir_up,
   output logic [OSC_W-1:0] nxt_osc,
   output logic [SUB_W-1:0] nxt_sub,
   output logic             out_of_range
);
   localparam logic [OSC_W-1:0] OSC_LAST = OSC_W'(NUM_OSC - 1);
   localparam logic [SUB_W-1:0] SUB_TOP  = '1;
   localparam logic [SUB_W-1:0] SUB_ONE  = SUB_W'(1);
   localparam logic [OSC_W-1:0] OSC_ONE  = OSC_W'(1);

   logic sub_edge;
   logic osc_edge;
   logic osc_bad;
   logic [OSC_W-1:0] carry_osc;

   generate
      if (NUM_OSC < 1 || NUM_OSC >= (1 << OSC_W)) begin : g_bad_count
         $error("vbs_stepper: NUM_OSC must leave one code free for shutdown");
      end
      if (NUM_OSC == 1) begin : g_single
         assign osc_edge  = 1'b1;
         assign carry_osc = osc;
      end else begin : g_multi
         assign osc_edge  = dir_up ? (osc == OSC_LAST) : (osc == '0);
         assign carry_osc = dir_up ? (osc + OSC_ONE) : (osc - OSC_ONE);
      end
   endgenerate

   always_comb begin
      sub_edge     = dir_up ? (sub == SUB_TOP) : (sub == '0);
      osc_bad      = (osc > OSC_LAST);
      nxt_sub      = dir_up ? (sub + SUB_ONE) : (sub - SUB_ONE);
      nxt_osc      = sub_edge ? carry_osc : osc;
      out_of_range = osc_bad | (sub_edge & osc_edge);
   end
endmodule

// File: rtl/vbs_settle_timer.sv
module vbs_settle_timer #(
   parameter int SEL_W    = 2,
   parameter int BASE_EXP = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [SEL_W-1:0] wait_sel,
   output logic             expire
);
   localparam int MAX_EXP = BASE_EXP + (1 << SEL_W) - 1;
   localparam int CNT_W   = MAX_EXP;

   logic [CNT_W-1:0] cnt;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W:0]   lim;

   generate
      if (BASE_EXP < 1) begin : g_bad_base
         $error("vbs_settle_timer: BASE_EXP must be at least 1");
      end
   endgenerate

   always_comb begin
      lim    = ((CNT_W+1)'(1) << (BASE_EXP + int'(sel_q))) - (CNT_W+1)'(1);
      expire = run && ({1'b0, cnt} == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sel_q <= '0;
      end else if (load) begin
         cnt   <= '0;
         sel_q <= wait_sel;
      end else if (run) begin
         cnt   <= expire ? '0 : cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
   import vbs_pkg::*;
#(
   parameter int OSC_W     = 2,
   parameter int SUB_W     = 4,
   parameter int NUM_OSC   = 3,
   parameter int CODE_W    = 3,
   parameter int SEL_W     = 2,
   parameter int BASE_EXP  = 6,
   parameter int MAX_TRIES = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retune,
   input  logic              srch_en,
   input  logic              seed_cur,
   input  logic [OSC_W-1:0]  man_osc,
   input  logic [SUB_W-1:0]  man_sub,
   input  logic [SEL_W-1:0]  settle_sel,
   input  logic [CODE_W-1:0] vt_code,
   output logic [OSC_W-1:0]  osc_sel,
   output logic [SUB_W-1:0]  sub_sel,
   output logic              srch_idle,
   output logic              srch_ok
);
   localparam int TRY_W = $clog2(MAX_TRIES + 1);
   localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("vco_band_search: MAX_TRIES must be at least 1");
      end
   endgenerate

   vbs_state_e       state;
   logic [OSC_W-1:0] cur_osc;
   logic [SUB_W-1:0] cur_sub;
   logic             ok_q;
   logic [TRY_W-1:0] tries;

   logic             start;
   logic             expire;
   vbs_act_e         act;
   logic [OSC_W-1:0] nxt_osc;
   logic [SUB_W-1:0] nxt_sub;
   logic             no_room;
   logic [OSC_W-1:0] seed_osc;
   logic [SUB_W-1:0] seed_sub;

   assign start    = retune & srch_en;
   assign seed_osc = seed_cur ? cur_osc : man_osc;
   assign seed_sub = seed_cur ? cur_sub : man_sub;

   vbs_settle_timer #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .run      (state == S_WAIT),
      .wait_sel (settle_sel),
      .expire   (expire)
   );

   vbs_code_decode #(.CODE_W(CODE_W)) u_decode (
      .code (vt_code),
      .act  (act)
   );

   vbs_stepper #(.OSC_W(OSC_W), .SUB_W(SUB_W), .NUM_OSC(NUM_OSC)) u_step (
      .osc          (cur_osc),
      .sub          (cur_sub),
      .dir_up       (act == ACT_UP),
      .nxt_osc      (nxt_osc),
      .nxt_sub      (nxt_sub),
      .out_of_range (no_room)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cur_osc <= '0;
         cur_sub <= '0;
         ok_q    <= 1'b0;
         tries   <= '0;
      end else if (!srch_en) begin
         state   <= S_IDLE;
         ok_q    <= 1'b0;
         cur_osc <= man_osc;
         cur_sub <= man_sub;
      end else if (start) begin
         state   <= S_WAIT;
         ok_q    <= 1'b0;
         cur_osc <= seed_osc;
         cur_sub <= seed_sub;
         tries   <= '0;
      end else if (state == S_WAIT && expire) begin
         if (cur_osc > OSC_W'(NUM_OSC - 1)) begin
            state <= S_IDLE;
            ok_q  <= 1'b0;
         end else if (act == ACT_LOCK) begin
            state <= S_IDLE;
            ok_q  <= 1'b1;
         end else if (no_room || tries == TRY_LAST) begin
            state <= S_IDLE;
            ok_q  <= 1'b0;
         end else begin
            cur_osc <= nxt_osc;
            cur_sub <= nxt_sub;
            tries   <= tries + TRY_W'(1);
         end
      end
   end

   assign osc_sel   = srch_en ? cur_osc : man_osc;
   assign sub_sel   = srch_en ? cur_sub : man_sub;
   assign srch_idle = (state == S_IDLE);
   assign srch_ok   = ok_q & srch_en;
endmodule

// File: rtl/vco_band_search_chk.sv
module vco_band_search_chk #(
   parameter int OSC_W     = 2,
   parameter int SUB_W     = 4,
   parameter int NUM_OSC   = 3,
   parameter int CODE_W    = 3,
   parameter int MAX_TRIES = 48,
   parameter int TRY_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              retune,
   input logic              srch_en,
   input logic [CODE_W-1:0] vt_code,
   input logic [OSC_W-1:0]  osc_sel,
   input logic [SUB_W-1:0]  sub_sel,
   input logic              srch_idle,
   input logic              srch_ok,
   input logic [TRY_W-1:0]  tries_cnt
);
   localparam logic [CODE_W-1:0] C_LO = '0;
   localparam logic [CODE_W-1:0] C_HI = '1;

   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retune && srch_en) |=> !srch_idle);

   // R2
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_en |=> srch_idle);

   // R6
   lock_only_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srch_ok) |-> ($past(!srch_idle) && $past(vt_code) != C_LO && $past(vt_code) != C_HI));

   // R6
   ok_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srch_ok |-> srch_idle);

   // R7
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!srch_idle && srch_en) |=> (!srch_en || $past(retune) || sub_sel == $past(sub_sel)
         || sub_sel == $past(sub_sel) + SUB_W'(1) || sub_sel == $past(sub_sel) - SUB_W'(1)));

   // R10
   tries_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tries_cnt < TRY_W'(MAX_TRIES));

   // R12
   ok_valid_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srch_ok |-> (osc_sel < OSC_W'(NUM_OSC)));
endmodule

bind vco_band_search vco_band_search_chk #(
   .OSC_W     (OSC_W),
   .SUB_W     (SUB_W),
   .NUM_OSC   (NUM_OSC),
   .CODE_W    (CODE_W),
   .MAX_TRIES (MAX_TRIES),
   .TRY_W     (TRY_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .retune    (retune),
   .srch_en   (srch_en),
   .vt_code   (vt_code),
   .osc_sel   (osc_sel),
   .sub_sel   (sub_sel),
   .srch_idle (srch_idle),
   .srch_ok   (srch_ok),
   .tries_cnt (tries)
);

// File: tb/vco_band_search_tb.sv
module vco_band_search_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       retune = 1'b0;
   logic       srch_en = 1'b1;
   logic       seed_cur = 1'b0;
   logic [1:0] man_osc = '0;
   logic [3:0] man_sub = '0;
   logic [1:0] settle_sel = '0;
   logic [2:0] vt_code;
   logic [1:0] osc_sel;
   logic [3:0] sub_sel;
   logic       srch_idle;
   logic       srch_ok;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int start_cyc = 0;
   int mode = 0;      // 0 lock at target, 1 always down, 2 always up, 3 bounce, 4 fixed lock code
   int target = 0;
   int idx;

   typedef struct {
      int osc;
      int sub;
      int ok;
      int cycles;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   vco_band_search u_dut (
      .clk(clk), .rst_n(rst_n), .retune(retune), .srch_en(srch_en), .seed_cur(seed_cur),
      .man_osc(man_osc), .man_sub(man_sub), .settle_sel(settle_sel), .vt_code(vt_code),
      .osc_sel(osc_sel), .sub_sel(sub_sel), .srch_idle(srch_idle), .srch_ok(srch_ok)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // tuning-code model driven from the selected setting
   always_comb begin
      idx = int'(osc_sel) * 16 + int'(sub_sel);
      case (mode)
         0: vt_code = (idx < target) ? 3'b111 : (idx > target) ? 3'b000 : 3'b011;
         1: vt_code = 3'b000;
         2: vt_code = 3'b111;
         3: vt_code = (idx == target) ? 3'b111 : 3'b000;
         default: vt_code = 3'b011;
      endcase
   end

   task automatic chk(input bit cond, input string req, input int act, input int expv);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // monitor: scoreboard pop on each completion
   logic prev_idle = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!prev_idle && srch_idle) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected completion", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(int'(osc_sel) == e.osc, {e.tag, " osc"}, int'(osc_sel), e.osc);
               chk(int'(sub_sel) == e.sub, {e.tag, " sub"}, int'(sub_sel), e.sub);
               chk(int'(srch_ok) == e.ok, {e.tag, " ok"}, int'(srch_ok), e.ok);
               chk((cyc - start_cyc) == e.cycles, {e.tag, " R5 time"}, cyc - start_cyc, e.cycles);
            end
         end
         prev_idle <= srch_idle;
      end
   end

   task automatic pulse_start(input int so, input int ss, input int ssel, input int w);
      man_osc = 2'(so);
      man_sub = 4'(ss);
      seed_cur = ssel[0];
      settle_sel = 2'(w);
      retune = 1'b1;
      @(negedge clk);
      retune = 1'b0;
      start_cyc = cyc;
   endtask

   task automatic wait_done();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_search(input int so, input int ss, input int ssel, input int w,
                             input int md, input int tgt, input int eo, input int es,
                             input int eok, input int samples, input string tag);
      exp_t e;
      @(negedge clk);
      mode = md;
      target = tgt;
      e.osc = eo; e.sub = es; e.ok = eok; e.cycles = samples * (64 << w); e.tag = tag;
      exp_q.push_back(e);
      pulse_start(so, ss, ssel, w);
      wait_done();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(srch_idle == 1'b1, "R1 idle", int'(srch_idle), 1);
      chk(srch_ok == 1'b0, "R1 ok", int'(srch_ok), 0);
      chk(osc_sel == 2'd0 && sub_sel == 4'd0, "R1 setting", int'(osc_sel) * 16 + int'(sub_sel), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 manual selection, pulse ignored
      srch_en = 1'b0;
      man_osc = 2'd1;
      man_sub = 4'd9;
      #1;
      chk(osc_sel == 2'd1 && sub_sel == 4'd9, "R2 follow", int'(osc_sel) * 16 + int'(sub_sel), 25);
      chk(srch_ok == 1'b0, "R2 ok low", int'(srch_ok), 0);
      @(negedge clk);
      retune = 1'b1;
      @(negedge clk);
      retune = 1'b0;
      repeat (3) @(negedge clk);
      chk(srch_idle == 1'b1, "R2 pulse ignored", int'(srch_idle), 1);
      srch_en = 1'b1;
      man_osc = 2'd0;
      man_sub = 4'd0;
      #1;
      // R4 setting in use tracked the manual fields while disabled
      chk(osc_sel == 2'd1 && sub_sel == 4'd9, "R4 in-use tracks manual", int'(osc_sel) * 16 + int'(sub_sel), 25);

      // R3 start drops idle next clock
      @(negedge clk);
      mode = 0;
      target = 19;
      begin
         exp_t e;
         e.osc = 1; e.sub = 3; e.ok = 1; e.cycles = 256; e.tag = "R6 lock wait2";
         exp_q.push_back(e);
      end
      pulse_start(1, 3, 0, 2);
      chk(srch_idle == 1'b0, "R3 busy", int'(srch_idle), 0);
      chk(srch_ok == 1'b0, "R3 ok clear", int'(srch_ok), 0);
      wait_done();

      run_search(1, 3, 0, 0, 0, 24, 1, 8, 1, 6, "R8 up steps");
      run_search(1, 1, 0, 0, 0, 13, 0, 13, 1, 5, "R7 down wrap");
      run_search(0, 14, 0, 0, 0, 18, 1, 2, 1, 5, "R8 up wrap");
      run_search(0, 2, 0, 0, 1, 0, 0, 0, 0, 3, "R9 low edge");
      run_search(2, 13, 0, 0, 2, 0, 2, 15, 0, 3, "R9 high edge");
      run_search(1, 4, 0, 0, 3, 20, 1, 5, 0, 48, "R10 try limit");
      run_search(3, 7, 0, 0, 4, 0, 3, 7, 0, 1, "R12 shutdown seed");
      run_search(2, 0, 0, 1, 0, 33, 2, 1, 1, 2, "R5 wait1");

      // R11 restart on the same edge as a scheduled sample
      @(negedge clk);
      mode = 0;
      target = 40;
      begin
         exp_t e;
         e.osc = 2; e.sub = 8; e.ok = 1; e.cycles = 6 * 64; e.tag = "R11 restart";
         exp_q.push_back(e);
      end
      pulse_start(0, 0, 0, 0);
      repeat (191) @(negedge clk);
      chk(srch_idle == 1'b0, "R11 still busy", int'(srch_idle), 0);
      pulse_start(2, 3, 0, 0);
      wait_done();

      // R4 resume from setting in use (2,8), manual fields point elsewhere
      run_search(0, 0, 1, 0, 0, 38, 2, 6, 1, 3, "R4 resume");

      chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule